// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two strobes that frame traffic on a multiplexed external bus: an active-high address-latch strobe (`ale`) and an active-low program-fetch read strobe (`psen_n`). It runs directly from the oscillator clock. A divide-by-two stage splits each state into two phases, so the logic does not depend on the duty cycle of the input clock. Six states make one machine cycle of twelve oscillator periods. The current state and phase are also brought out for neighbouring logic.

At the edge that closes each machine cycle, the block samples four flags and holds them for the whole of the next machine cycle. The flags are: external code execution, an external data access, a table read, and an address-strobe disable bit that software sets. In an external data cycle, the early address strobe and both fetch strobes are skipped. While the disable bit is set, the address strobe rests high. It pulses only in data or table-read cycles. External execution overrides the disable bit.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: `phase` toggles on every clock. `state` steps 0,1,2,3,4,5,0,... on each clock where `phase` was 1, so one machine cycle is 12 clocks. Here `state`=k stands for machine state k+1.
- R2: When the strobe is not suppressed and the cycle has no external data access, `ale` is high exactly while `phase`=1 in state 0 and in state 3. That gives two one-clock pulses per machine cycle.
- R3: In a machine cycle flagged as an external data access, the state-0 `ale` pulse is dropped and the state-3 pulse is kept.
- R4: With external execution flagged and no external data access, `psen_n` is low during states 1, 2, 4 and 5 (both phases) and high in states 0 and 3. Without external execution, `psen_n` stays high.
- R5: In a machine cycle flagged as an external data access, `psen_n` stays high for the whole cycle, even under external execution.
- R6: With the disable bit set, no external execution, and neither a data access nor a table read flagged, `ale` is held at 1 for the whole machine cycle.
- R7: With the disable bit set and a data access or table read flagged, `ale` follows the pulse pattern of R2 and R3.
- R8: With external execution flagged, the disable bit has no effect on `ale`.
- R9: The four flags are sampled at the clock edge that leaves state 5 phase 1, and only there; a flag change at any other time has no effect until the next machine cycle. Reset sets `state`=0 and `phase`=0 and clears the sampled flags, which leaves `ale` enabled and `psen_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_exec | input | 1 | Code is fetched from external program memory |
| xdata_acc | input | 1 | Next machine cycle is an external data access |
| table_rd | input | 1 | Next machine cycle is a table read |
| ale_dis | input | 1 | Software bit that suppresses the address strobe |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-fetch read strobe, active low |
| state | output | 3 | Machine state 0..5 |
| phase | output | 1 | Phase within the state, 0 or 1 |

## Verification
All outputs are decoded from registers and have no combinational input path. A flag driven before the cycle-closing edge therefore first shows at the start of the following machine cycle and applies to all twelve of its clocks. The bench's reference model advances a 0..11 counter at each rising edge. It captures the inputs only when that counter wraps, and compares `state`, `phase`, `ale` and `psen_n` at every falling edge. Inputs also change at falling edges, including changes in the middle of a cycle. A directed pulse of the data flag that ends before the wrap checks that it leaves the following state-0 strobe in place.

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_exec,
  input  logic       xdata_acc,
  input  logic       table_rd,
  input  logic       ale_dis,
  output logic       ale,
  output logic       psen_n,
  output logic [2:0] state,
  output logic       phase
);
  localparam logic [2:0] LAST_ST  = 3'd5;
  localparam logic [2:0] EARLY_ST = 3'd0;
  localparam logic [2:0] LATE_ST  = 3'd3;

  logic [2:0] st;
  logic       ph;
  logic       ext_q, xd_q, tb_q, dis_q;
  logic       cyc_end;

  assign cyc_end = ph && (st == LAST_ST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= 3'd0;
      ph    <= 1'b0;
      ext_q <= 1'b0;
      xd_q  <= 1'b0;
      tb_q  <= 1'b0;
      dis_q <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) st <= (st == LAST_ST) ? 3'd0 : st + 3'd1;
      if (cyc_end) begin
        ext_q <= ext_exec;
        xd_q  <= xdata_acc;
        tb_q  <= table_rd;
        dis_q <= ale_dis;
      end
    end
  end

  logic ale_slot, ale_hold, fetch_slot;

  assign ale_slot   = ph && (((st == EARLY_ST) && !xd_q) || (st == LATE_ST));
  assign ale_hold   = dis_q && !ext_q && !xd_q && !tb_q;
  assign fetch_slot = (st == 3'd1) || (st == 3'd2) || (st == 3'd4) || (st == 3'd5);

  assign ale    = ale_hold || ale_slot;
  assign psen_n = !(ext_q && !xd_q && fetch_slot);
  assign state  = st;
  assign phase  = ph;

  p_phase_toggle_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase != $past(phase)));

  p_state_step_r1: assert property (@(posedge clk) disable iff (rst)
    phase |=> (state == (($past(state) == LAST_ST) ? 3'd0 : $past(state) + 3'd1)));

  p_state_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(state));

  p_ale_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |-> (phase || (state == 3'd0 && !phase)));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(ale && !psen_n));

  p_fetch_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |=> !psen_n);

  p_flags_held_r9: assert property (@(posedge clk) disable iff (rst)
    !cyc_end |=> ($stable(xd_q) && $stable(ext_q) && $stable(tb_q) && $stable(dis_q)));
endmodule

// File: tb/ext_bus_strobe_gen_tb.sv
module ext_bus_strobe_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_exec = 1'b0, xdata_acc = 1'b0, table_rd = 1'b0, ale_dis = 1'b0;
  logic       ale, psen_n, phase;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  int mk = 0;
  bit m_ext = 0, m_xd = 0, m_tb = 0, m_dis = 0;

  always #10 clk = ~clk;

  ext_bus_strobe_gen dut_i (
    .clk(clk), .rst(rst), .ext_exec(ext_exec), .xdata_acc(xdata_acc),
    .table_rd(table_rd), .ale_dis(ale_dis), .ale(ale), .psen_n(psen_n),
    .state(state), .phase(phase)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (mk=%0d)", req, what, act, exp, mk);
    end
  endtask

  task automatic compare_all();
    bit supp, e_ale, e_psen;
    string areq, preq;
    supp   = m_dis && !m_ext && !m_xd && !m_tb;
    e_ale  = supp ? 1'b1 : (((mk == 1) && !m_xd) || (mk == 7));
    e_psen = !(m_ext && !m_xd && ((mk >= 2 && mk <= 5) || (mk >= 8)));
    if (supp)                areq = "R6";
    else if (m_dis && m_ext) areq = "R8";
    else if (m_dis)          areq = "R7";
    else if (m_xd)           areq = "R3";
    else                     areq = "R2";
    preq = (m_xd && m_ext) ? "R5" : "R4";
    chk("R1", "state", int'(state), mk / 2);
    chk("R1", "phase", int'(phase), mk % 2);
    chk(areq, "ale", int'(ale), int'(e_ale));
    chk(preq, "psen_n", int'(psen_n), int'(e_psen));
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      mk = 0; m_ext = 0; m_xd = 0; m_tb = 0; m_dis = 0;
    end else begin
      if (mk == 11) begin
        m_ext = ext_exec; m_xd = xdata_acc; m_tb = table_rd; m_dis = ale_dis;
      end
      mk = (mk + 1) % 12;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_flags(input bit e, input bit x, input bit t, input bit d);
    ext_exec = e; xdata_acc = x; table_rd = t; ale_dis = d;
  endtask

  initial begin
    ext_exec = 1'b1; xdata_acc = 1'b1; ale_dis = 1'b1;
    repeat (3) @(negedge clk);
    step();
    // R9: reset state, sampled flags cleared
    chk("R9", "reset state", int'(state), 0);
    chk("R9", "reset phase", int'(phase), 0);
    chk("R9", "reset ale", int'(ale), 0);
    chk("R9", "reset psen_n", int'(psen_n), 1);
    rst = 1'b0;
    set_flags(0, 0, 0, 0);
    repeat (24) step();
    // every combination of flags, one machine cycle each, then twice more
    for (int n = 0; n < 48; n++) begin
      set_flags(n[0], n[1], n[2], n[3]);
      repeat (12) step();
    end
    // R9: a data-flag pulse in mid-cycle that ends before the wrap must not act
    set_flags(1, 0, 0, 0);
    while (mk != 0) step();
    repeat (4) step();
    xdata_acc = 1'b1;
    repeat (3) step();
    xdata_acc = 1'b0;
    while (mk != 1) step();
    chk("R9", "ale after short data pulse", int'(ale), 1);
    // R8: disable bit with external execution and no table/data access
    set_flags(1, 0, 0, 1);
    while (mk != 0) step();
    step();
    chk("R8", "ale pulse despite disable", int'(ale), 1);
    // random changes at arbitrary times
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        ext_exec  = 1'($urandom_range(0, 1));
        xdata_acc = 1'($urandom_range(0, 1));
        table_rd  = 1'($urandom_range(0, 1));
        ale_dis   = 1'($urandom_range(0, 1));
      end
      step();
    end
    // mid-run reset
    rst = 1'b1;
    step();
    chk("R9", "re-reset state", int'(state), 0);
    rst = 1'b0;
    set_flags(0, 0, 0, 1);
    repeat (36) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule